// File: doc/BRIEF.md
# Microframe Index Counter

This block keeps the running microframe index of a USB host controller. A clock-cycle prescaler marks the end of each 125 µs microframe. At each of these marks the 14-bit index steps by one and a start-of-frame strobe goes high for one cycle. The host can use that strobe as its time base. The low three index bits count the eight microframes of a 1 ms frame. The bits above them address the frame list.

A rollover strobe reports each time the frame-list part of the index wraps to zero. The wrap point depends on the programmed frame list size. The block watches one index bit chosen by the size code and raises the strobe whenever that bit toggles on an advance. Counting runs only while the run/stop input is 1. While the controller is halted, software may load the index directly.

Top module: `uframe_index_counter`

## Requirements
- R1: A synchronous active-high reset sets the index to 0 and holds both strobes at 0.
- R2: While run is 1, the index increases by exactly 1 once every TICKS_PER_UFRAME clock cycles.
- R3: The SOF strobe is high for exactly one cycle, in the cycle in which the new index value first appears.
- R4: While run is 0, the index holds its value and no strobe fires. The prescaler restarts, so the first advance comes TICKS_PER_UFRAME cycles after run returns to 1.
- R5: When run is 0, a write loads the write data into the index one cycle later, and no strobe fires.
- R6: When run is 1, a write is ignored and the index keeps counting from its own value.
- R7: With size code 0 (1024 entries), the rollover strobe fires exactly on those advances that toggle index bit 13.
- R8: With size code 1 (512 entries), the rollover strobe fires exactly on those advances that toggle index bit 12. A toggle of bit 11 gives no strobe.
- R9: With size code 2 (256 entries), and with the unused code 3, the rollover strobe fires exactly on those advances that toggle index bit 11.
- R10: The rollover strobe is only ever high together with the SOF strobe.
- R11: The index wraps from 0x3FFF to 0x0000, and with size code 0 that advance gives a rollover strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run/stop: 1 counts microframes, 0 halts |
| size_code | input | 2 | Frame list size: 0=1024, 1=512, 2 or 3=256 |
| idx_we | input | 1 | Index write strobe, honoured only while halted |
| idx_wdata | input | IDX_W (14) | Value loaded into the index |
| frame_index | output | IDX_W (14) | Current microframe index |
| sof_pulse | output | 1 | One-cycle strobe at each microframe advance |
| rollover_pulse | output | 1 | One-cycle strobe when the frame list wraps |

## Verification
Corrupted prescaler state shows up at the first following advance. The gap between SOF strobes comes out shorter or longer than TICKS_PER_UFRAME cycles, so an error is visible within one microframe. A wrong index value or a write accepted while running appears on frame_index in the next cycle. A wrong rollover-bit selection shows only at the advance where the relevant bit toggles. For that reason the bench loads the index just below each bit-11, bit-12 and bit-13 boundary, which exposes this kind of fault within two microframes.

// File: rtl/ufi_pkg.sv
`timescale 1ns/1ps
package ufi_pkg;
  // Number of index bits below the frame-list field (microframes per frame = 8)
  localparam int UFRAME_BITS = 3;

  // Position of the index bit whose toggle signals a frame-list wrap.
  // Code 0 -> top bit, 1 -> one below, 2 and 3 -> two below.
  function automatic int roll_bit(input int idx_w, input logic [1:0] code);
    int drop;
    drop = (code > 2'd2) ? 2 : int'(code);
    return idx_w - 1 - drop;
  endfunction
endpackage

// File: rtl/ufi_prescaler.sv
`timescale 1ns/1ps
module ufi_prescaler #(
  parameter int TICKS = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/ufi_index_reg.sv
`timescale 1ns/1ps
module ufi_index_reg #(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             we,
  input  logic [IDX_W-1:0] wdata,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_next,
  output logic             sof
);
  logic [IDX_W-1:0] idx_q;
  logic             sof_q;

  assign idx_next = idx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      sof_q <= 1'b0;
    end else begin
      sof_q <= tick;
      if (tick) begin
        idx_q <= idx_next;
      end else if (we && !run) begin
        idx_q <= wdata;
      end
    end
  end

  assign idx = idx_q;
  assign sof = sof_q;
endmodule

// File: rtl/ufi_rollover_detect.sv
`timescale 1ns/1ps
module ufi_rollover_detect
  import ufi_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       size_code,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] idx_next,
  output logic             roll
);
  logic [IDX_W-1:0] flip;
  logic             sel_flip;
  logic             roll_q;

  assign flip     = idx ^ idx_next;
  assign sel_flip = flip[roll_bit(IDX_W, size_code)];

  always_ff @(posedge clk) begin
    if (rst) begin
      roll_q <= 1'b0;
    end else begin
      roll_q <= tick && sel_flip;
    end
  end

  assign roll = roll_q;
endmodule

// File: rtl/uframe_index_counter.sv
`timescale 1ns/1ps
module uframe_index_counter #(
  parameter int IDX_W            = 14,
  parameter int TICKS_PER_UFRAME = 25000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [1:0]       size_code,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  output logic [IDX_W-1:0] frame_index,
  output logic             sof_pulse,
  output logic             rollover_pulse
);
  logic             tick;
  logic [IDX_W-1:0] idx_cur;
  logic [IDX_W-1:0] idx_nxt;

  ufi_prescaler #(.TICKS(TICKS_PER_UFRAME)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  ufi_index_reg #(.IDX_W(IDX_W)) u_idx (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .we       (idx_we),
    .wdata    (idx_wdata),
    .idx      (idx_cur),
    .idx_next (idx_nxt),
    .sof      (sof_pulse)
  );

  ufi_rollover_detect #(.IDX_W(IDX_W)) u_roll (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .size_code (size_code),
    .idx       (idx_cur),
    .idx_next  (idx_nxt),
    .roll      (rollover_pulse)
  );

  assign frame_index = idx_cur;
endmodule

// File: rtl/uframe_index_counter_chk.sv
`timescale 1ns/1ps
module uframe_index_counter_chk
  import ufi_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic [1:0]       size_code,
  input logic             idx_we,
  input logic [IDX_W-1:0] frame_index,
  input logic             sof_pulse,
  input logic             rollover_pulse
);
  logic [IDX_W-1:0] prev_idx;
  logic [1:0]       prev_code;
  logic             sel_changed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_idx  <= '0;
      prev_code <= '0;
    end else begin
      prev_idx  <= frame_index;
      prev_code <= size_code;
    end
  end

  assign sel_changed = (frame_index[roll_bit(IDX_W, prev_code)] !=
                        prev_idx[roll_bit(IDX_W, prev_code)]);

  AST_SOF_STEP: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> (frame_index == IDX_W'($past(frame_index) + 1'b1))); // R3

  AST_HALT_NO_SOF: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> !sof_pulse); // R4

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(idx_we)) |-> $stable(frame_index)); // R4

  AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !sof_pulse) |-> $stable(frame_index)); // R6

  AST_ROLL_WITH_SOF: assert property (@(posedge clk) disable iff (rst)
    rollover_pulse |-> sof_pulse); // R10

  AST_ROLL_NEEDS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    rollover_pulse |-> sel_changed); // R7

  AST_TOGGLE_GIVES_ROLL: assert property (@(posedge clk) disable iff (rst)
    (sof_pulse && sel_changed) |-> rollover_pulse); // R8
endmodule

bind uframe_index_counter uframe_index_counter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .run            (run),
  .size_code      (size_code),
  .idx_we         (idx_we),
  .frame_index    (frame_index),
  .sof_pulse      (sof_pulse),
  .rollover_pulse (rollover_pulse)
);

// File: tb/uframe_index_counter_tb.sv
`timescale 1ns/1ps
module uframe_index_counter_tb;
  localparam int IDX_W = 14;
  localparam int TICKS = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             run = 1'b0;
  logic [1:0]       size_code = 2'd0;
  logic             idx_we = 1'b0;
  logic [IDX_W-1:0] idx_wdata = '0;
  logic [IDX_W-1:0] frame_index;
  logic             sof_pulse;
  logic             rollover_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  uframe_index_counter #(.IDX_W(IDX_W), .TICKS_PER_UFRAME(TICKS)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .run            (run),
    .size_code      (size_code),
    .idx_we         (idx_we),
    .idx_wdata      (idx_wdata),
    .frame_index    (frame_index),
    .sof_pulse      (sof_pulse),
    .rollover_pulse (rollover_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Wait for the next SOF strobe; report cycles taken and the rollover value.
  task automatic next_uframe(output int cyc, output logic roll);
    cyc = 0;
    roll = 1'b0;
    do begin
      @(posedge clk); #1;
      cyc++;
    end while (!sof_pulse && cyc < 50);
    roll = rollover_pulse;
  endtask

  task automatic halt();
    @(negedge clk); run = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_idx(input logic [IDX_W-1:0] v);
    @(negedge clk); idx_we = 1'b1; idx_wdata = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic t_reset();
    check(frame_index == 0, "R1 index", int'(frame_index), 0);
    check(sof_pulse == 0, "R1 sof", int'(sof_pulse), 0);
    check(rollover_pulse == 0, "R1 roll", int'(rollover_pulse), 0);
  endtask

  task automatic t_count();
    int cyc; logic roll;
    size_code = 2'd0;
    @(negedge clk); run = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      next_uframe(cyc, roll);
      check(cyc == TICKS, "R2 period", cyc, TICKS);
      check(frame_index == IDX_W'(i), "R2 index", int'(frame_index), i);
      check(sof_pulse == 1'b1, "R3 sof seen", int'(sof_pulse), 1);
    end
    @(posedge clk); #1;
    check(sof_pulse == 1'b0, "R3 one-cycle width", int'(sof_pulse), 0);
    check(frame_index == IDX_W'(5), "R3 index holds between strobes", int'(frame_index), 5);
  endtask

  task automatic t_halt();
    int cyc; logic roll; logic [IDX_W-1:0] held; int seen;
    halt();
    held = frame_index;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      if (sof_pulse || rollover_pulse) seen++;
    end
    check(frame_index == held, "R4 index held", int'(frame_index), int'(held));
    check(seen == 0, "R4 no strobes", seen, 0);
    @(negedge clk); run = 1'b1;
    next_uframe(cyc, roll);
    check(cyc == TICKS, "R4 restart period", cyc, TICKS);
    check(frame_index == held + 1'b1, "R4 resume index", int'(frame_index), int'(held) + 1);
  endtask

  task automatic t_write_halted();
    halt();
    @(negedge clk); idx_we = 1'b1; idx_wdata = 14'h1234;
    @(posedge clk); #1;
    check(frame_index == 14'h1234, "R5 load", int'(frame_index), 'h1234);
    check(!sof_pulse && !rollover_pulse, "R5 no strobe", int'({sof_pulse, rollover_pulse}), 0);
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic t_write_running();
    int cyc; logic roll; logic [IDX_W-1:0] base;
    @(negedge clk); run = 1'b1;
    next_uframe(cyc, roll);
    base = frame_index;
    @(negedge clk); idx_we = 1'b1; idx_wdata = 14'h0AAA;
    @(posedge clk); #1;
    check(frame_index == base, "R6 write ignored", int'(frame_index), int'(base));
    @(negedge clk); idx_we = 1'b0;
    next_uframe(cyc, roll);
    check(frame_index == base + 1'b1, "R6 keeps counting", int'(frame_index), int'(base) + 1);
  endtask

  // Load start, run two microframes, and check the rollover on each advance.
  task automatic t_roll(input logic [1:0] code, input logic [IDX_W-1:0] start,
                        input logic exp1, input logic exp2, input string req);
    int cyc; logic roll;
    halt();
    size_code = code;
    write_idx(start);
    @(negedge clk); run = 1'b1;
    next_uframe(cyc, roll);
    check(roll == exp1, {req, " first advance"}, int'(roll), int'(exp1));
    next_uframe(cyc, roll);
    check(roll == exp2, {req, " second advance"}, int'(roll), int'(exp2));
    check(frame_index == IDX_W'(start + 2), {req, " index"}, int'(frame_index), int'(IDX_W'(start + 2)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_count();
    t_halt();
    t_write_halted();
    t_write_running();
    t_roll(2'd0, 14'h1FFE, 1'b0, 1'b1, "R7 bit13 rise");
    t_roll(2'd0, 14'h0FFE, 1'b0, 1'b0, "R7 bit12 ignored");
    t_roll(2'd1, 14'h0FFE, 1'b0, 1'b1, "R8 bit12");
    t_roll(2'd1, 14'h07FE, 1'b0, 1'b0, "R8 bit11 ignored");
    t_roll(2'd2, 14'h07FE, 1'b0, 1'b1, "R9 code2 bit11");
    t_roll(2'd3, 14'h17FE, 1'b0, 1'b1, "R9 code3 bit11");
    t_roll(2'd0, 14'h3FFE, 1'b0, 1'b1, "R11 wrap");
    check(frame_index == 14'h0000, "R11 wrapped to zero", int'(frame_index), 0);
    t_roll(2'd0, 14'h0000, 1'b0, 1'b0, "R10 no roll mid-list");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule